// File: doc/BRIEF.md
# Pipelined converter code deskew bank

A pipelined converter resolves each sample a few bits at a time in a chain of stages. Neighbouring stages run on opposite clock phases, so the code from stage i of one sample appears i half clocks after the code from the first stage of the same sample. This block collects the per-stage codes, holds each one in a delay lane matched to its stage position, and presents one assembled word per clock. The first stage's code sits in the most significant bits of that word.

Each lane captures its stage code on the clock phase that stage uses. It then moves the code forward on rising edges only, into a shared rising-edge output register. Lanes for early stages are longer than lanes for late stages. A strobe that accompanies the first stage's code travels beside the data and becomes the output valid flag. The number of stages and the bits per stage are parameters. The latency in whole clocks is M = ceil(NUM_STAGES/2).

Top module: `dsk_deskew_bank`

## Requirements
- R1: Stage i is numbered from 0, where stage 0 is the first and most significant stage. Its code is taken from `stage_codes[(NUM_STAGES-1-i)*STAGE_BITS +: STAGE_BITS]`. For sample n, whose first-stage code is captured at rising edge n, stage i is captured as follows. If i is even, it is captured at rising edge n + i/2. If i is odd, it is captured at the falling edge that follows rising edge n + (i-1)/2.
- R2: The output word places the code of stage i at `out_word[(NUM_STAGES-1-i)*STAGE_BITS +: STAGE_BITS]`, so stage 0 occupies the most significant bits.
- R3: The word for sample n appears on `out_word` after rising edge n + M, where M = ceil(NUM_STAGES/2).
- R4: `out_valid` after rising edge n + M equals `in_strobe` as sampled at rising edge n.
- R5: With a new sample on every clock, a new assembled word leaves on every clock, with no gaps and no repeats.
- R6: `out_valid` stays low for the first M rising edges after reset ends, whatever `in_strobe` does.
- R7: `rst` is synchronous and active high. It clears every lane register on the lane's own edge and the output register, so `out_valid` and `out_word` are 0 after a rising edge with `rst` high. Codes captured before the reset never reach the output.
- R8: A stage input is only sampled at its own capture edge. Any value it carries at the opposite-phase edge has no effect on the output. The same holds for `in_strobe` at falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; rising and falling edges both used |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Marks a real sample; timed with the first stage's code |
| stage_codes | input | NUM_STAGES*STAGE_BITS | Per-stage codes, stage 0 in the top slice |
| out_valid | output | 1 | Assembled word is a real sample |
| out_word | output | NUM_STAGES*STAGE_BITS | Time-aligned word, stage 0 in the top slice |

## Verification
The hardest situation to reach from the ports is one where each stage input holds the right code only around its own capture edge, while a wrong value sits there at the opposite edge. The bench produces this by re-driving every stage input on every half clock. Each input gets the proper code just before its capture edge and random data just before the other edge, so a lane on the wrong phase picks up noise. A second hard case is a reset that arrives while samples are still in flight in the lanes. The bench stops a stream without draining it and resets at once, then expects `out_valid` to stay low for M clocks.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
    // whole-clock latency from first-stage capture to the output register
    function automatic int latency_of(input int stages);
        return (stages + 1) / 2;
    endfunction

    // rising-edge registers a lane needs between its capture and the output register
    function automatic int rise_depth(input int lat, input int idx);
        return lat - 1 - (idx / 2);
    endfunction
endpackage

// File: rtl/dsk_lane.sv
`timescale 1ns/1ps
module dsk_lane #(
    parameter int W   = 2,
    parameter int IDX = 0,
    parameter int M   = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] lane_out
);
    localparam bit ON_FALL = (IDX % 2) == 1;
    localparam int DEPTH   = dsk_pkg::rise_depth(M, IDX);

    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = rst ? '0 : code_in;
    end

    generate
        if (ON_FALL) begin : g_fall_cap
            always_ff @(negedge clk) begin
                cap_q <= cap_d;
            end
        end else begin : g_rise_cap
            always_ff @(posedge clk) begin
                cap_q <= cap_d;
            end
        end

        if (DEPTH > 0) begin : g_chain
            logic [DEPTH-1:0][W-1:0] sh_d, sh_q;

            always_comb begin
                sh_d = sh_q;
                if (rst) begin
                    sh_d = '0;
                end else begin
                    sh_d[0] = cap_q;
                    for (int j = 1; j < DEPTH; j++) begin
                        sh_d[j] = sh_q[j-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                sh_q <= sh_d;
            end

            assign lane_out = sh_q[DEPTH-1];
        end else begin : g_direct
            assign lane_out = cap_q;
        end
    endgenerate
endmodule

// File: rtl/dsk_strobe_pipe.sv
`timescale 1ns/1ps
module dsk_strobe_pipe #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic strobe_out
);
    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        if (rst) begin
            pipe_d = '0;
        end else begin
            pipe_d[0] = strobe_in;
            for (int j = 1; j < DEPTH; j++) begin
                pipe_d[j] = pipe_q[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign strobe_out = pipe_q[DEPTH-1];
endmodule

// File: rtl/dsk_deskew_bank.sv
`timescale 1ns/1ps
module dsk_deskew_bank #(
    parameter int NUM_STAGES = 5,
    parameter int STAGE_BITS = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_strobe,
    input  logic [NUM_STAGES*STAGE_BITS-1:0] stage_codes,
    output logic                             out_valid,
    output logic [NUM_STAGES*STAGE_BITS-1:0] out_word
);
    localparam int WW = NUM_STAGES * STAGE_BITS;
    localparam int M  = dsk_pkg::latency_of(NUM_STAGES);

    typedef struct packed {
        logic          valid;
        logic [WW-1:0] word;
    } out_t;

    out_t out_d, out_q;

    logic [STAGE_BITS-1:0] lane_w [NUM_STAGES];
    logic                  strobe_w;

    generate
        for (genvar g = 0; g < NUM_STAGES; g++) begin : g_lane
            dsk_lane #(
                .W   (STAGE_BITS),
                .IDX (g),
                .M   (M)
            ) lane_i (
                .clk      (clk),
                .rst      (rst),
                .code_in  (stage_codes[(NUM_STAGES-1-g)*STAGE_BITS +: STAGE_BITS]),
                .lane_out (lane_w[g])
            );
        end
    endgenerate

    dsk_strobe_pipe #(
        .DEPTH (M)
    ) strobe_i (
        .clk        (clk),
        .rst        (rst),
        .strobe_in  (in_strobe),
        .strobe_out (strobe_w)
    );

    always_comb begin
        out_d = out_q;
        if (rst) begin
            out_d = '0;
        end else begin
            out_d.valid = strobe_w;
            for (int i = 0; i < NUM_STAGES; i++) begin
                out_d.word[(NUM_STAGES-1-i)*STAGE_BITS +: STAGE_BITS] = lane_w[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_word  = out_q.word;
endmodule

// File: rtl/dsk_deskew_bank_chk.sv
`timescale 1ns/1ps
module dsk_deskew_bank_chk #(
    parameter int NUM_STAGES = 5,
    parameter int STAGE_BITS = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             in_strobe,
    input logic [NUM_STAGES*STAGE_BITS-1:0] stage_codes,
    input logic                             out_valid,
    input logic [NUM_STAGES*STAGE_BITS-1:0] out_word
);
    localparam int WW = NUM_STAGES * STAGE_BITS;
    localparam int M  = dsk_pkg::latency_of(NUM_STAGES);

    logic                  armed_q = 1'b0;
    logic [M:0]            stb_sh;
    logic [STAGE_BITS-1:0] top_sh [M+1];
    int                    since_rst;

    always_ff @(posedge clk) begin
        armed_q <= armed_q | rst;
        if (rst) begin
            stb_sh    <= '0;
            since_rst <= 0;
            for (int j = 0; j <= M; j++) top_sh[j] <= '0;
        end else begin
            stb_sh    <= {stb_sh[M-1:0], in_strobe};
            top_sh[0] <= stage_codes[WW-1 -: STAGE_BITS];
            for (int j = 1; j <= M; j++) top_sh[j] <= top_sh[j-1];
            if (since_rst < M) since_rst <= since_rst + 1;
        end
    end

    // R4: valid flag trails the strobe by the fixed latency
    a_r4_valid_tracks_strobe: assert property (@(posedge clk) disable iff (rst || !armed_q)
        out_valid == stb_sh[M]);

    // R3: first-stage lane delivers its code after M clocks, in the top slice
    a_r3_top_lane_delay: assert property (@(posedge clk) disable iff (rst || !armed_q)
        out_word[WW-1 -: STAGE_BITS] == top_sh[M]);

    // R6: no valid word before the deepest lane has filled
    a_r6_no_early_valid: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (since_rst < M) |-> !out_valid);

    // R7: a reset edge leaves the output cleared
    a_r7_reset_clears: assert property (@(posedge clk) disable iff (!armed_q)
        $past(rst) |-> (!out_valid && out_word == '0));
endmodule

bind dsk_deskew_bank dsk_deskew_bank_chk #(
    .NUM_STAGES (NUM_STAGES),
    .STAGE_BITS (STAGE_BITS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_strobe   (in_strobe),
    .stage_codes (stage_codes),
    .out_valid   (out_valid),
    .out_word    (out_word)
);

// File: tb/dsk_deskew_bank_tb_top.sv
`timescale 1ns/1ps
module dsk_deskew_bank_tb_top;
    localparam int S    = 5;
    localparam int K    = 2;
    localparam int WW   = S * K;
    localparam int M    = (S + 1) / 2;
    localparam int NMAX = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_strobe = 1'b0;
    logic [WW-1:0] stage_codes = '0;
    logic          out_valid;
    logic [WW-1:0] out_word;

    int total = 0;
    int bad   = 0;
    int nsamp = 0;

    logic [K-1:0] cd [NMAX][S];
    bit           vp [NMAX];

    always #2.5 clk = ~clk;

    dsk_deskew_bank #(.NUM_STAGES(S), .STAGE_BITS(K)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_strobe   (in_strobe),
        .stage_codes (stage_codes),
        .out_valid   (out_valid),
        .out_word    (out_word)
    );

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // set every input for the capture edge at half index h+1; off-phase inputs get noise (R8)
    task automatic drive(input int h);
        int cap;
        cap = h + 1;
        for (int i = 0; i < S; i++) begin
            if (((cap - i) & 1) == 0) begin
                int n;
                n = (cap - i) / 2;
                stage_codes[(S-1-i)*K +: K] = (n >= 0 && n < nsamp) ? cd[n][i] : '0;
            end else begin
                stage_codes[(S-1-i)*K +: K] = K'($urandom);
            end
        end
        if ((cap & 1) == 0) begin
            int n;
            n = cap / 2;
            in_strobe = (n >= 0 && n < nsamp) ? vp[n] : 1'b0;
        end else begin
            in_strobe = 1'($urandom);
        end
    endtask

    task automatic fill(input int mode, input int ns);
        nsamp = ns;
        for (int n = 0; n < ns; n++) begin
            vp[n] = (mode == 1) ? ((n % 3) != 1) : 1'b1;
            for (int i = 0; i < S; i++) begin
                if (mode == 2) cd[n][i] = ((n + i) % 2 == 1) ? '1 : '0;
                else           cd[n][i] = K'($urandom);
            end
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        in_strobe = 1'b0;
        stage_codes = '0;
        @(posedge clk);
        #1;
        chk("R7 reset valid", WW'(out_valid), '0);
        chk("R7 reset word", out_word, '0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        drive(-1);
    endtask

    task automatic run(input bit drain);
        int last;
        last = drain ? (nsamp + M - 1) : (nsamp - 1);
        for (int h = 0; h <= 2 * last; h++) begin
            if ((h & 1) == 0) @(posedge clk);
            else              @(negedge clk);
            #1;
            if ((h & 1) == 0) begin
                int k, n;
                logic ev;
                logic [WW-1:0] ew;
                k = h / 2;
                n = k - M;
                ev = (n >= 0 && n < nsamp) ? vp[n] : 1'b0;
                if (n < 0) chk("R6 valid low while filling", WW'(out_valid), WW'(ev));
                else       chk("R4 valid follows strobe", WW'(out_valid), WW'(ev));
                if (n >= 0) begin
                    ew = '0;
                    if (n < nsamp)
                        for (int i = 0; i < S; i++) ew[(S-1-i)*K +: K] = cd[n][i];
                    chk("R1 R2 R3 R5 R8 aligned word", out_word, ew);
                end
            end
            if (h < 2 * last) drive(h);
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL R5 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        fill(0, 20);          // back-to-back random samples
        do_reset();
        run(1'b1);
        fill(1, 24);          // gapped strobes, stopped mid-flight
        do_reset();
        run(1'b0);
        fill(2, 16);          // alternating extreme codes, R7 flush of previous stream
        do_reset();
        run(1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule